// File: doc/BRIEF.md
# Stereo Volume Ramp with Master Offset

This block produces the running attenuation for the two channels of a stereo audio path. Each channel has its own 8-bit volume code. A shared master code adds attenuation on top of both. All codes and outputs count in 0.5 dB units below the +36 dB ceiling, so code 0 is +36 dB. The outputs step toward their targets one unit at a time on a per-sample strobe, so a change of setting never lands as one jump. The sample multiplier downstream reads the two attenuation outputs.

A mute request drives both channels toward the mute level together. The fade is paced at one unit per sixteen sample strobes. When the request is released, the gain climbs back at the same slow pace. After both channels are back on their targets, the block returns to fast tracking. A muted flag tells the system when the fade-out is complete.

Top module: `stereo_vol`

## Requirements
- R1: After reset both attenuation outputs equal the mute level 283 and `muted` is 1.
- R2: A channel's target attenuation is its channel code plus the master code, in 0.5 dB units below +36 dB. For example, channel 0x00 with master 0x18 gives 24, which is +24 dB.
- R3: A target sum of 282 (-105 dB) is kept as it is. Any sum above 282 becomes the mute level 283. An output never exceeds 283.
- R4: Without a mute request, and outside a fade-in, each output moves one unit toward its target on every clock with `sampleStrobe` high. An output never changes on a clock without the strobe.
- R5: While `muteReq` is 1, both outputs rise by one unit every sixteen strobes and saturate at 283. The count restarts on the clock where the pacing mode changes; a strobe on that clock is not counted. The first step therefore lands on the sixteenth strobe after that clock.
- R6: After `muteReq` falls, both outputs descend toward their targets at one unit per sixteen strobes, counted as in R5. One clock after both outputs sit on their targets, tracking returns to one unit per strobe.
- R7: `muted` is 1 exactly when both outputs equal 283.
- R8: The left code affects only `leftAtt`, and the right code affects only `rightAtt`.
- R9: Volume code changes made during a mute request do not alter the fade toward 283.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| leftCode | input | 8 | Left channel volume code, 0.5 dB units below +36 dB |
| rightCode | input | 8 | Right channel volume code |
| masterCode | input | 8 | Master attenuation added to both channels |
| muteReq | input | 1 | Request a soft mute of both channels |
| sampleStrobe | input | 1 | One-clock pulse per audio sample |
| leftAtt | output | 9 | Current left attenuation; 283 means muted |
| rightAtt | output | 9 | Current right attenuation; 283 means muted |
| muted | output | 1 | Both channels at the mute level |

## Verification
Two events can fall on the same clock: the pacing mode changes, and a sample strobe arrives. That strobe must be excluded from the sixteen-strobe count. The bench raises or drops `muteReq` one clock before a burst of strobes. It then checks that the outputs hold through fifteen strobes and move on the sixteenth, for both the fade-out and the fade-in. The second overlap is the end of a fade-in meeting a new code. The bench waits one clock after both channels land on their targets before changing a code. It then expects a step on the very next strobe.

// File: rtl/stereo_vol_pkg.sv
package stereo_vol_pkg;

  typedef enum logic [1:0] {
    MODE_TRACK    = 2'd0,
    MODE_FADE_OUT = 2'd1,
    MODE_FADE_IN  = 2'd2
  } rampMode_t;

  typedef struct packed {
    logic stepEn;
    logic toMute;
  } rampCmd_t;

endpackage

// File: rtl/stereo_vol_target.sv
module stereo_vol_target #(
  parameter int CODE_W   = 8,
  parameter int ATT_W    = CODE_W + 1,
  parameter int MUTE_ATT = 283
) (
  input  logic [CODE_W-1:0] chanCode,
  input  logic [CODE_W-1:0] masterCode,
  input  logic              toMute,
  output logic [ATT_W-1:0]  target
);
  localparam int SUM_W = CODE_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {1'b0, chanCode} + {1'b0, masterCode};
    if (toMute || (int'(sum) >= MUTE_ATT)) target = ATT_W'(MUTE_ATT);
    else                                   target = ATT_W'(sum);
  end
endmodule

// File: rtl/stereo_vol_ctrl.sv
module stereo_vol_ctrl
  import stereo_vol_pkg::*;
#(
  parameter int SLOW_DIV = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     muteReq,
  input  logic     sampleStrobe,
  input  logic     allAtTarget,
  output rampCmd_t cmd
);
  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOW_DIV - 1);

  rampMode_t       modeNow;
  rampMode_t       modeQ;
  logic            recovering;
  logic [CNT_W-1:0] slowCnt;
  logic            slowMode;
  logic            slowTick;

  always_comb begin
    if (muteReq)         modeNow = MODE_FADE_OUT;
    else if (recovering) modeNow = MODE_FADE_IN;
    else                 modeNow = MODE_TRACK;
    slowMode = (modeNow != MODE_TRACK);
    slowTick = sampleStrobe && slowMode && (modeNow == modeQ) && (slowCnt == CNT_LAST);
    cmd.toMute = (modeNow == MODE_FADE_OUT);
    cmd.stepEn = slowMode ? slowTick : sampleStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= MODE_TRACK;
      recovering <= 1'b0;
      slowCnt    <= '0;
    end else begin
      modeQ <= modeNow;
      if (muteReq)          recovering <= 1'b1;
      else if (allAtTarget) recovering <= 1'b0;
      if (modeNow != modeQ)            slowCnt <= '0;
      else if (slowMode && sampleStrobe) slowCnt <= slowCnt + 1'b1;
    end
  end
endmodule

// File: rtl/stereo_vol_path.sv
module stereo_vol_path
  import stereo_vol_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int ATT_W    = CODE_W + 1,
  parameter int MUTE_ATT = 283,
  parameter int NUM_CH   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0][CODE_W-1:0] chanCode,
  input  logic [CODE_W-1:0]             masterCode,
  input  rampCmd_t                      cmd,
  output logic [NUM_CH-1:0][ATT_W-1:0]  att,
  output logic                          allAtTarget
);
  logic [NUM_CH-1:0] atTarget;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [ATT_W-1:0] target;

    stereo_vol_target #(
      .CODE_W  (CODE_W),
      .ATT_W   (ATT_W),
      .MUTE_ATT(MUTE_ATT)
    ) u_target (
      .chanCode  (chanCode[ch]),
      .masterCode(masterCode),
      .toMute    (cmd.toMute),
      .target    (target)
    );

    assign atTarget[ch] = (att[ch] == target);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        att[ch] <= ATT_W'(MUTE_ATT);
      end else if (cmd.stepEn) begin
        if (att[ch] < target)      att[ch] <= att[ch] + 1'b1;
        else if (att[ch] > target) att[ch] <= att[ch] - 1'b1;
      end
    end
  end

  assign allAtTarget = &atTarget;
endmodule

// File: rtl/stereo_vol.sv
module stereo_vol
  import stereo_vol_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int MUTE_ATT = 283,
  parameter int SLOW_DIV = 16,
  localparam int ATT_W   = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] leftCode,
  input  logic [CODE_W-1:0] rightCode,
  input  logic [CODE_W-1:0] masterCode,
  input  logic              muteReq,
  input  logic              sampleStrobe,
  output logic [ATT_W-1:0]  leftAtt,
  output logic [ATT_W-1:0]  rightAtt,
  output logic              muted
);
  rampCmd_t                   cmd;
  logic                       allAtTarget;
  logic [1:0][CODE_W-1:0]     codes;
  logic [1:0][ATT_W-1:0]      atts;

  assign codes = {rightCode, leftCode};

  stereo_vol_ctrl #(.SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .muteReq     (muteReq),
    .sampleStrobe(sampleStrobe),
    .allAtTarget (allAtTarget),
    .cmd         (cmd)
  );

  stereo_vol_path #(
    .CODE_W  (CODE_W),
    .ATT_W   (ATT_W),
    .MUTE_ATT(MUTE_ATT),
    .NUM_CH  (2)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .chanCode   (codes),
    .masterCode (masterCode),
    .cmd        (cmd),
    .att        (atts),
    .allAtTarget(allAtTarget)
  );

  assign leftAtt  = atts[0];
  assign rightAtt = atts[1];
  assign muted    = (atts[0] == ATT_W'(MUTE_ATT)) && (atts[1] == ATT_W'(MUTE_ATT));
endmodule

// File: rtl/stereo_vol_chk.sv
module stereo_vol_chk #(
  parameter int ATT_W    = 9,
  parameter int MUTE_ATT = 283
) (
  input logic             clk,
  input logic             rstN,
  input logic             muteReq,
  input logic             sampleStrobe,
  input logic [ATT_W-1:0] leftAtt,
  input logic [ATT_W-1:0] rightAtt,
  input logic             muted
);
  // R3: never beyond the mute level
  p_att_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(leftAtt) <= MUTE_ATT) && (int'(rightAtt) <= MUTE_ATT));

  // R4: no movement without a strobe
  p_hold_no_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> ($stable(leftAtt) && $stable(rightAtt)));

  // R4: at most one unit per clock
  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> ((leftAtt == $past(leftAtt)) || (leftAtt == $past(leftAtt) + 1'b1) ||
                      (leftAtt + 1'b1 == $past(leftAtt))));

  // R5: a mute request only ever adds attenuation
  p_fade_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    muteReq |=> ((leftAtt >= $past(leftAtt)) && (rightAtt >= $past(rightAtt))));

  // R5: fading steps are never back to back
  p_fade_slow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (muteReq && $changed(leftAtt)) |=> $stable(leftAtt));

  // R7: once muted, a held request keeps it muted
  p_muted_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (muteReq && muted) |=> muted);
endmodule

bind stereo_vol stereo_vol_chk #(
  .ATT_W   (ATT_W),
  .MUTE_ATT(MUTE_ATT)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .muteReq     (muteReq),
  .sampleStrobe(sampleStrobe),
  .leftAtt     (leftAtt),
  .rightAtt    (rightAtt),
  .muted       (muted)
);

// File: tb/stereo_vol_tb.sv
module stereo_vol_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MUTE = 283;
  localparam int NVEC = 6;
  // {left, right, master, expLeft, expRight}
  localparam logic [41:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'h18, 9'd24,  9'd24 },
    {8'h10, 8'h20, 8'h00, 9'd16,  9'd32 },
    {8'hFF, 8'hFE, 8'h1B, 9'd282, 9'd281},
    {8'hFF, 8'h00, 8'h1C, 9'd283, 9'd28 },
    {8'h80, 8'h01, 8'h00, 9'd128, 9'd1  },
    {8'h00, 8'h00, 8'h00, 9'd0,   9'd0  }
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] leftCode = '0, rightCode = '0, masterCode = '0;
  logic       muteReq = 1'b0, sampleStrobe = 1'b0;
  logic [8:0] leftAtt, rightAtt;
  logic       muted;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_vol u_dut (
    .clk(clk), .rstN(rstN), .leftCode(leftCode), .rightCode(rightCode),
    .masterCode(masterCode), .muteReq(muteReq), .sampleStrobe(sampleStrobe),
    .leftAtt(leftAtt), .rightAtt(rightAtt), .muted(muted)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sampleStrobe = 1'b1;
      @(negedge clk) sampleStrobe = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 left", leftAtt, MUTE);
    check("R1 right", rightAtt, MUTE);
    check("R1 muted", muted, 1);

    // R4: no strobe, no movement
    repeat (5) @(negedge clk);
    check("R4 hold", leftAtt, MUTE);
    pulse(1);
    check("R4 one step", leftAtt, MUTE - 1);
    check("R7 flag clears", muted, 0);

    // R2 R3 R8 table walk
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {leftCode, rightCode, masterCode} = VEC[v][41:18];
      pulse(300);
      check("R2/R3/R8 left", leftAtt, int'(VEC[v][17:9]));
      check("R2/R3/R8 right", rightAtt, int'(VEC[v][8:0]));
    end

    // R5: fade-out timing (both outputs at 0 now)
    @(negedge clk) muteReq = 1'b1;
    pulse(15);
    check("R5 held 15 strobes", leftAtt, 0);
    pulse(1);
    check("R5 first step left", leftAtt, 1);
    check("R5 first step right", rightAtt, 1);
    pulse(16);
    check("R5 second step", leftAtt, 2);
    check("R7 not yet muted", muted, 0);
    pulse(16 * 281);
    check("R5 reach mute", leftAtt, MUTE);
    check("R7 muted", muted, 1);
    // R9: code change during mute has no effect
    @(negedge clk) leftCode = 8'h10;
    pulse(32);
    check("R9 still muted left", leftAtt, MUTE);
    check("R5 saturate right", rightAtt, MUTE);

    // R6: fade-in
    @(negedge clk) rightCode = 8'h20;
    @(negedge clk) muteReq = 1'b0;
    pulse(15);
    check("R6 held 15 strobes", leftAtt, MUTE);
    pulse(1);
    check("R6 first step", leftAtt, MUTE - 1);
    check("R7 unmuting", muted, 0);
    pulse(16 * 250);
    check("R6 right lands", rightAtt, 32);
    pulse(16);
    check("R6 slow left", leftAtt, 31);
    check("R6 right stays", rightAtt, 32);
    pulse(16 * 15);
    check("R6 left lands", leftAtt, 16);
    @(negedge clk);
    @(negedge clk) leftCode = 8'h00;
    pulse(1);
    check("R6 fast tracking again", leftAtt, 15);
    check("R8 right untouched", rightAtt, 32);

    finishRun();
  end
endmodule